// File: doc/BRIEF.md
# Programmable Oversampling Tick Generator

This block turns the system clock into a periodic single-cycle strobe at sixteen times the serial bit rate. The strobe paces both the transmit and receive serial engines. The rate comes from a divisor of `DIV_W` bits, which is held in byte-wide registers. A bus decoder writes each byte through its own strobe. Counting only advances on cycles where the qualifying input `baud_en` is high. That input can be tied high to run from the system clock alone, or driven from a slower external rate source that has been turned into one-cycle enables.

Any write to a divisor byte restarts the count from the updated divisor on the same clock edge that stores the byte. A new rate therefore takes hold at once, instead of after a long count left over from the old setting. A divisor of zero parks the generator with no strobes. Alongside the strobe, a level output flips on every strobe, so the rate can be watched from outside.

Top module: `baud_tick_gen`

## Requirements
- R1: After reset the divisor reads 0, `tick` is 0 and `baud_out` is 0.
- R2: `wr_byte[0]` loads `wr_data` into divisor bits 7:0 and `wr_byte[1]` loads bits 15:8. A byte whose strobe is low keeps its value. Both strobes may be high in the same cycle. `divisor` shows the stored value from the clock edge that samples the write.
- R3: While the divisor is 0, `tick` never rises, whatever `baud_en` does.
- R4: With a divisor N greater than 1 and `baud_en` high on every cycle, `tick` is high for exactly the one cycle after the N-th clock edge that follows the write edge. It then repeats every N edges.
- R5: With a divisor of 1, `tick` is high after every edge at which `baud_en` was high.
- R6: A write to either byte in the middle of a count discards the count. No `tick` follows the write edge, and the first `tick` comes N enabled edges after the write edge, where N is the new divisor.
- R7: Only edges where `baud_en` was high advance the count. While `baud_en` stays low there is no `tick`. If `baud_en` is high one cycle in every M, the strobe spacing is N×M edges.
- R8: `baud_out` inverts on every edge that raises `tick` and holds otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_byte | input | DIV_W/8 | Per-byte divisor write strobes, bit 0 = low byte |
| wr_data | input | 8 | Byte written to the selected divisor register(s) |
| baud_en | input | 1 | Count qualifier; tie high for system-clock operation |
| divisor | output | DIV_W | Currently stored divisor |
| tick | output | 1 | One-cycle 16x-rate strobe |
| baud_out | output | 1 | Level that flips on every strobe |

## Verification
The properties assume that `wr_byte`, `wr_data` and `baud_en` carry known values once reset is released, and that they change only away from the active clock edge. The bench drives every input on the falling edge and never leaves them undriven. The checker does not assume that an external enable has any particular spacing. That is why the bench can hold `baud_en` permanently high, or pulse it one cycle in two or three, and still exercise the periodic strobe.

// File: rtl/baud_pkg.sv
package baud_pkg;
    localparam int unsigned BYTE_W = 8;
    typedef logic [BYTE_W-1:0] byte_t;
endpackage

// File: rtl/baud_divreg.sv
module baud_divreg
    import baud_pkg::*;
#(
    parameter int unsigned NUM_BYTES = 2,
    localparam int unsigned DIV_W = NUM_BYTES * BYTE_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_BYTES-1:0] wr_byte,
    input  byte_t                wr_data,
    output logic [DIV_W-1:0]     div_q,
    output logic [DIV_W-1:0]     div_next,
    output logic                 load
);
    logic [NUM_BYTES-1:0][BYTE_W-1:0] byte_d;
    logic [NUM_BYTES-1:0][BYTE_W-1:0] byte_q;

    for (genvar b = 0; b < NUM_BYTES; b++) begin : g_byte
        always_comb begin
            byte_d[b] = wr_byte[b] ? wr_data : byte_q[b];
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) byte_q[b] <= '0;
            else        byte_q[b] <= byte_d[b];
        end
    end

    // The counter is loaded from the merged next value, so the restart
    // lands on the same edge that stores the byte.
    assign div_next = byte_d;
    assign div_q    = byte_q;
    assign load     = |wr_byte;
endmodule

// File: rtl/baud_counter.sv
module baud_counter #(
    parameter int unsigned DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [DIV_W-1:0] div_next,
    input  logic [DIV_W-1:0] div_q,
    input  logic             en,
    output logic             tick,
    output logic             bout
);
    localparam logic [DIV_W-1:0] CNT_ONE = DIV_W'(1);

    typedef struct packed {
        logic [DIV_W-1:0] cnt;
        logic             tick;
        logic             bout;
    } cnt_state_t;

    cnt_state_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.tick = 1'b0;
        if (load) begin
            st_d.cnt = div_next;
        end else if (en && (div_q != '0)) begin
            if (st_q.cnt <= CNT_ONE) begin
                st_d.cnt  = div_q;
                st_d.tick = 1'b1;
                st_d.bout = ~st_q.bout;
            end else begin
                st_d.cnt = st_q.cnt - CNT_ONE;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign tick = st_q.tick;
    assign bout = st_q.bout;
endmodule

// File: rtl/baud_tick_gen.sv
module baud_tick_gen
    import baud_pkg::*;
#(
    parameter int unsigned DIV_W = 16,
    localparam int unsigned NUM_BYTES = DIV_W / BYTE_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_BYTES-1:0] wr_byte,
    input  logic [BYTE_W-1:0]    wr_data,
    input  logic                 baud_en,
    output logic [DIV_W-1:0]     divisor,
    output logic                 tick,
    output logic                 baud_out
);
    logic [DIV_W-1:0] div_next;
    logic             load;

    baud_divreg #(
        .NUM_BYTES(NUM_BYTES)
    ) u_divreg (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_byte (wr_byte),
        .wr_data (wr_data),
        .div_q   (divisor),
        .div_next(div_next),
        .load    (load)
    );

    baud_counter #(
        .DIV_W(DIV_W)
    ) u_counter (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (load),
        .div_next(div_next),
        .div_q   (divisor),
        .en      (baud_en),
        .tick    (tick),
        .bout    (baud_out)
    );
endmodule

// File: rtl/baud_tick_gen_chk.sv
module baud_tick_gen_chk #(
    parameter int unsigned DIV_W = 16,
    parameter int unsigned NUM_BYTES = 2
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [NUM_BYTES-1:0] wr_byte,
    input logic                 baud_en,
    input logic [DIV_W-1:0]     divisor,
    input logic                 tick,
    input logic                 baud_out
);
    assert_inputs_known_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !$isunknown({wr_byte, baud_en}));

    assert_div_holds_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_byte == '0) |=> $stable(divisor));

    assert_zero_div_silent_R3: assert property (@(posedge clk) disable iff (!rst_n)
        tick |-> (divisor != '0));

    assert_div1_every_en_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ((divisor == DIV_W'(1)) && baud_en && (wr_byte == '0)) |=> tick);

    assert_no_tick_after_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_byte != '0) |=> !tick);

    assert_tick_needs_en_R7: assert property (@(posedge clk) disable iff (!rst_n)
        tick |-> $past(baud_en));

    assert_bout_flips_R8: assert property (@(posedge clk) disable iff (!rst_n)
        tick |-> (baud_out != $past(baud_out)));

    assert_bout_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |-> $stable(baud_out));
endmodule

bind baud_tick_gen baud_tick_gen_chk #(
    .DIV_W    (DIV_W),
    .NUM_BYTES(NUM_BYTES)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_byte (wr_byte),
    .baud_en (baud_en),
    .divisor (divisor),
    .tick    (tick),
    .baud_out(baud_out)
);

// File: tb/tb_baud_tick_gen.sv
module tb_baud_tick_gen;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  wr_byte = 2'b00;
    logic [7:0]  wr_data = 8'h00;
    logic        baud_en = 1'b0;
    logic [15:0] divisor;
    logic        tick;
    logic        baud_out;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    baud_tick_gen dut (
        .clk(clk), .rst_n(rst_n), .wr_byte(wr_byte), .wr_data(wr_data),
        .baud_en(baud_en), .divisor(divisor), .tick(tick), .baud_out(baud_out)
    );

    typedef struct packed {
        int dv;
        int en_mod;
        int gap;
    } vec_t;

    localparam int NV = 8;
    localparam vec_t VEC [NV] = '{
        '{1, 1, 1}, '{2, 1, 2}, '{3, 1, 3}, '{7, 1, 7},
        '{300, 1, 300}, '{4, 2, 8}, '{5, 3, 15}, '{1, 2, 2}
    };

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] m, input logic [7:0] d);
        @(negedge clk);
        wr_byte = m;
        wr_data = d;
        @(posedge clk);
        @(negedge clk);
        wr_byte = 2'b00;
    endtask

    // Returns at the negedge after the write edge; edge k after it counted from 1.
    task automatic run_ticks(input int m, input int maxc, output int t1, output int t2,
                             output logic b1, output logic b2);
        t1 = -1; t2 = -1; b1 = 1'b0; b2 = 1'b0;
        baud_en = ((1 % m) == 0);
        for (int cyc = 1; cyc <= maxc; cyc++) begin
            @(posedge clk);
            @(negedge clk);
            if (tick) begin
                if (t1 < 0) begin t1 = cyc; b1 = baud_out; end
                else if (t2 < 0) begin t2 = cyc; b2 = baud_out; end
            end
            if (t2 >= 0) break;
            baud_en = (((cyc + 1) % m) == 0);
        end
    endtask

    task automatic count_ticks(input int n, output int cnt);
        cnt = 0;
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            @(negedge clk);
            if (tick) cnt++;
        end
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        int t1, t2, n;
        logic b1, b2;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check(divisor == 16'h0, "R1 divisor", divisor, 0);
        check(tick == 1'b0, "R1 tick", tick, 0);
        check(baud_out == 1'b0, "R1 baud_out", baud_out, 0);

        // R3: zero divisor after reset stays silent
        baud_en = 1'b1;
        count_ticks(60, n);
        check(n == 0, "R3 zero divisor after reset", n, 0);

        // Vector table: R4, R5, R7, R8
        for (int v = 0; v < NV; v++) begin
            wr(2'b01, VEC[v].dv[7:0]);
            wr(2'b10, VEC[v].dv[15:8]);
            check(divisor == VEC[v].dv[15:0], "R2 divisor readback", divisor, VEC[v].dv);
            run_ticks(VEC[v].en_mod, 2000, t1, t2, b1, b2);
            if (VEC[v].dv == 1 && VEC[v].en_mod == 1)
                check(t1 == 1 && t2 == 2, "R5 tick every cycle", t2 - t1, 1);
            else
                check(t1 == VEC[v].gap, "R4 R7 first tick", t1, VEC[v].gap);
            check(t2 - t1 == VEC[v].gap, "R4 R7 tick spacing", t2 - t1, VEC[v].gap);
            check(b1 != b2, "R8 baud_out flips", b2, !b1);
        end

        // R2: independent bytes and dual write
        wr(2'b10, 8'h00);
        wr(2'b01, 8'h34);
        check(divisor == 16'h0034, "R2 low byte", divisor, 16'h0034);
        wr(2'b10, 8'h12);
        check(divisor == 16'h1234, "R2 high byte", divisor, 16'h1234);
        wr(2'b01, 8'hAB);
        check(divisor == 16'h12AB, "R2 low keeps high", divisor, 16'h12AB);
        wr(2'b11, 8'h5C);
        check(divisor == 16'h5C5C, "R2 both bytes", divisor, 16'h5C5C);

        // R6: mid-count reload
        baud_en = 1'b1;
        wr(2'b10, 8'h00);
        wr(2'b01, 8'd10);
        count_ticks(4, n);
        check(n == 0, "R6 no tick before reload", n, 0);
        wr(2'b01, 8'd3);
        run_ticks(1, 50, t1, t2, b1, b2);
        check(t1 == 3, "R6 first tick after reload", t1, 3);

        // R7: held-low enable freezes the count
        wr(2'b01, 8'd2);
        baud_en = 1'b0;
        count_ticks(20, n);
        check(n == 0, "R7 no tick with enable low", n, 0);
        check(divisor == 16'd2, "R7 divisor kept", divisor, 2);
        run_ticks(1, 50, t1, t2, b1, b2);
        check(t1 == 2, "R7 resumes from held count", t1, 2);

        // R3: writing zero silences a running generator
        wr(2'b01, 8'd5);
        wr(2'b01, 8'd0);
        baud_en = 1'b1;
        count_ticks(40, n);
        check(n == 0, "R3 zero divisor written", n, 0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule